// File: doc/BRIEF.md
# Multiplexed-Bus Register File Slave

This block is a byte-wide register file that sits on a shared 8-bit address/data bus. A host first puts a register index on the bus and pulses an address strobe. Then it moves one byte to or from the selected register over the same pins. It does this with active-low read and write strobes, qualified by an active-low chip select. The bidirectional bus is split into an input, an output and an output-enable, so a pad or tristate buffer at the chip edge can join them.

All bus pins are asynchronous to the block clock. The strobes and the bus byte pass through a two-flop synchronizer. An extra history stage follows the synchronizer, so edges can be detected and the byte present just before each edge can be captured. The array holds 128 bytes, and only the low seven bits of the latched index select an entry.

Top module: `mbus_regfile`

## Requirements
- R1: After reset, `adOe` is 0, `adOut` is 0x00 and every register reads back 0x00.
- R2: On a falling edge of `ale` while `rdN` and `wrN` are both high, the byte on `adIn` becomes the register index.
- R3: A falling edge of `ale` while `rdN` or `wrN` is low leaves the index unchanged.
- R4: A rising edge of `wrN` while `csN` is low stores the `adIn` byte into the indexed register.
- R5: A `wrN` pulse while `csN` is high changes no register.
- R6: While `csN` and `rdN` are both low, `adOe` is 1 and `adOut` carries the indexed register, within three clock cycles.
- R7: While `csN` is high, `adOe` stays 0 even if `rdN` is low, and `adOut` is 0x00 whenever `adOe` is 0.
- R8: Within three clock cycles after `rdN` or `csN` returns high, `adOe` is 0 again.
- R9: Bit 7 of the index byte is ignored, so index 0x90 selects register 0x10.
- R10: The index latch works whether `csN` is high or low.
- R11: The index persists across later accesses until the next qualified `ale` falling edge.

Active-low chip select: `csN`. Active-low read and write strobes: `rdN` and `wrN`. Active-high address strobe: `ale`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adIn | input | 8 | Shared bus, receive side |
| adOut | output | 8 | Shared bus, drive side |
| adOe | output | 1 | Drive enable for the shared bus |
| ale | input | 1 | Address strobe, index taken on falling edge |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |

## Verification
On every cycle, the embedded properties check the following:
- A write and an index capture never fire together.
- The index moves only after a capture strobe.
- A register changes only after a write strobe.
- The drive enable never rises unless chip select and read were both low at the pins three cycles earlier.
- The output byte stays zero while the bus is not driven.

The values themselves can only be shown by the bench's scenarios. These cover the data read back after writes, the ignored eighth index bit, and the index surviving across accesses. They also cover a rejected capture while a data strobe is low, and a write attempt with chip select high.

// File: rtl/mbreg_pkg.sv
package mbreg_pkg;
  // strobes issued by control, one cycle wide, toward the datapath
  typedef struct packed {
    logic aleLatch;  // capture index
    logic wrEn;      // store byte
    logic rdEn;      // read window open
  } mbStrobe_t;

  // bit positions inside the synchronized strobe vector
  localparam int unsigned ALE_B = 3;
  localparam int unsigned CS_B  = 2;
  localparam int unsigned RD_B  = 1;
  localparam int unsigned WR_B  = 0;
  localparam int unsigned NSTB  = 4;
endpackage

// File: rtl/mbreg_sync.sv
module mbreg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RSTV  = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dSync,
  output logic [W-1:0] dPrev
);
  localparam int unsigned NPIPE = STAGES + 1;

  logic [W-1:0] pipe [NPIPE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPIPE; i++) pipe[i] <= RSTV;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < NPIPE; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dSync = pipe[STAGES-1];
  assign dPrev = pipe[STAGES];
endmodule

// File: rtl/mbreg_ctrl.sv
module mbreg_ctrl
  import mbreg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSTB-1:0] stbNow,
  input  logic [NSTB-1:0] stbPrev,
  output mbStrobe_t       st,
  output logic            adOe
);
  logic aleFall, wrRise, rdOpen, idleBefore;

  // data strobes both inactive in the sample before the edge
  assign idleBefore = stbPrev[RD_B] & stbPrev[WR_B];
  assign aleFall    = stbPrev[ALE_B] & ~stbNow[ALE_B] & idleBefore;
  assign wrRise     = ~stbPrev[WR_B] & stbNow[WR_B] & ~stbPrev[CS_B];
  assign rdOpen     = ~stbNow[CS_B] & ~stbNow[RD_B];

  always_comb begin
    st          = '0;
    st.aleLatch = aleFall;
    st.wrEn     = wrRise;
    st.rdEn     = rdOpen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) adOe <= 1'b0;
    else       adOe <= rdOpen;
  end

  // R4
  wr_latch_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(st.wrEn && st.aleLatch));
endmodule

// File: rtl/mbreg_dp.sv
module mbreg_dp
  import mbreg_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 128
) (
  input  logic          clk,
  input  logic          rstN,
  input  mbStrobe_t     st,
  input  logic [DW-1:0] busPrev,
  output logic [DW-1:0] adOut
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW-1:0] addrQ;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      adOut <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (st.aleLatch) addrQ <= busPrev[AW-1:0];
      if (st.wrEn)     mem[addrQ] <= busPrev;
      adOut <= st.rdEn ? mem[addrQ] : '0;
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(addrQ) |-> $past(st.aleLatch));

  // R5
  mem_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(addrQ) && !$past(st.wrEn)) |-> $stable(mem[addrQ]));
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
  import mbreg_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 128,
  parameter int unsigned SYNC  = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] adIn,
  output logic [DW-1:0] adOut,
  output logic          adOe,
  input  logic          ale,
  input  logic          csN,
  input  logic          rdN,
  input  logic          wrN
);
  logic [NSTB-1:0] stbRaw, stbNow, stbPrev;
  logic [DW-1:0]   busNow, busPrev;
  mbStrobe_t       st;

  always_comb begin
    stbRaw        = '0;
    stbRaw[ALE_B] = ale;
    stbRaw[CS_B]  = csN;
    stbRaw[RD_B]  = rdN;
    stbRaw[WR_B]  = wrN;
  end

  // strobes reset to their idle level: ale low, active-low pins high
  mbreg_sync #(.W(NSTB), .STAGES(SYNC), .RSTV(4'b0111)) uStbSync (
    .clk(clk), .rstN(rstN), .din(stbRaw), .dSync(stbNow), .dPrev(stbPrev));

  mbreg_sync #(.W(DW), .STAGES(SYNC), .RSTV('0)) uBusSync (
    .clk(clk), .rstN(rstN), .din(adIn), .dSync(busNow), .dPrev(busPrev));

  mbreg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .stbNow(stbNow), .stbPrev(stbPrev),
    .st(st), .adOe(adOe));

  mbreg_dp #(.DW(DW), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .busPrev(busPrev), .adOut(adOut));

  logic unusedBus;
  assign unusedBus = ^busNow;

  // R7
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !adOe |-> (adOut == '0));

  // R6
  oe_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (!$past(csN, 3) && !$past(rdN, 3)));
endmodule

// File: tb/sim_mbus_regfile.sv
module sim_mbus_regfile;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] adIn = 8'h00;
  logic [7:0] adOut;
  logic       adOe;
  logic       ale = 1'b0, csN = 1'b1, rdN = 1'b1, wrN = 1'b1;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbus_regfile u0 (.clk(clk), .rstN(rstN), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .ale(ale), .csN(csN), .rdN(rdN), .wrN(wrN));

  // op byte: 1 = write data, 0 = read and expect data
  localparam logic [23:0] VEC [8] = '{
    {8'd1, 8'h10, 8'hA5}, {8'd1, 8'h7F, 8'h3C}, {8'd1, 8'h00, 8'hFF},
    {8'd0, 8'h10, 8'hA5}, {8'd0, 8'h7F, 8'h3C}, {8'd0, 8'h00, 8'hFF},
    {8'd1, 8'h90, 8'h5A}, {8'd0, 8'h10, 8'h5A}};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latchIdx(input logic [7:0] a);
    adIn = a; ale = 1'b1; waitN(4);
    ale = 1'b0; waitN(4);
  endtask

  task automatic writeCur(input logic [7:0] d);
    adIn = d; csN = 1'b0; wrN = 1'b0; waitN(4);
    wrN = 1'b1; waitN(4);
    csN = 1'b1; waitN(2);
  endtask

  task automatic readCur(input string tag, input logic [7:0] exp);
    csN = 1'b0; rdN = 1'b0; waitN(5);
    chk({tag, " R6 oe"}, {7'd0, adOe}, 8'h01);
    chk({tag, " R6 data"}, adOut, exp);
    rdN = 1'b1; csN = 1'b1; waitN(5);
    chk({tag, " R8 oe off"}, {7'd0, adOe}, 8'h00);
  endtask

  initial begin
    waitN(3);
    // R1: reset state
    chk("R1 oe", {7'd0, adOe}, 8'h00);
    chk("R1 out", adOut, 8'h00);
    rstN = 1'b1; waitN(3);
    latchIdx(8'h05); readCur("R1 reg05", 8'h00);
    latchIdx(8'h7F); readCur("R1 reg7F", 8'h00);

    // vector table: R2, R4, R6, R9, R10
    foreach (VEC[i]) begin
      latchIdx(VEC[i][15:8]);
      if (VEC[i][23:16] == 8'd1) writeCur(VEC[i][7:0]);
      else readCur($sformatf("R2 R10 vec%0d", i), VEC[i][7:0]);
    end

    // R3 and R11: capture rejected while read strobe low; index keeps 0x20
    latchIdx(8'h20); writeCur(8'h11);
    adIn = 8'h30; ale = 1'b1; waitN(4);
    rdN = 1'b0; waitN(4);
    ale = 1'b0; waitN(4);
    rdN = 1'b1; waitN(4);
    writeCur(8'h22);
    readCur("R11 same index", 8'h22);
    latchIdx(8'h30); readCur("R3 reg30 untouched", 8'h00);

    // R5: write pulse with chip select high
    latchIdx(8'h40);
    adIn = 8'h77; wrN = 1'b0; waitN(4); wrN = 1'b1; waitN(4);
    readCur("R5 reg40", 8'h00);

    // R7: read strobe without chip select
    rdN = 1'b0; waitN(5);
    chk("R7 oe", {7'd0, adOe}, 8'h00);
    chk("R7 out", adOut, 8'h00);
    rdN = 1'b1; waitN(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule